// File: doc/BRIEF.md
# Dual-Point PWM Channel Generator

This block produces one pulse-width-modulated waveform from a register-style configuration. A two-stage prescaler turns the input clock into a time quantum: an 8-bit linear factor plus one, shifted left by a 4-bit exponent. An 8-bit duty counter steps once per quantum and wraps after reaching the programmed period value. The output goes active when the count reaches a start compare point and goes inactive again at an end compare point. If the two points are equal, the output stays active for the whole period.

Software writes two 32-bit words, each with its own write strobe. The control word carries the divider fields and four single-bit controls: counter run, pin enable, invert and sync disable. The timing word carries the two compare points and the period. Writes to the divider, period and compare fields go into staging registers. The running copy picks them up when the counter wraps, so a period never mixes old and new settings. Setting the sync-disable bit makes those writes take effect at once. The run, pin-enable and invert bits always act immediately. The block exports three signals: the raw modulated level before inversion and pin gating, the output-enable flag, and the final pin value.

Top module: `pwm_dual_point_chan`

## Requirements
- R1: One quantum lasts (Q+1) << S input clocks, where Q is control bits 7:0 and S is control bits 11:8. One waveform period lasts (P+1) quanta, where P is timing-word bits 31:24. The duty counter wraps to zero after the quantum in which it equals P.
- R2: With run set, `pwm_level` is 1 while the count lies in [A, B). A is timing-word bits 7:0 and B is timing-word bits 15:8. When A > B the active interval wraps through the period end, so the level is 1 for counts >= A or counts < B.
- R3: When A equals B and run is set, `pwm_level` is 1 in every cycle.
- R4: While run (control bit 16) is 0, the duty counter is held at zero and `pwm_level` is 0. Clearing run mid-period drops the level on the next cycle. Setting run again restarts the count at zero, using any timing written while run was 0.
- R5: While pin enable (control bit 12) is 0, `pwm_oe` is 0 and `pwm_pin` holds the inactive level, which equals the invert bit.
- R6: While pin enable is 1, `pwm_pin` equals `pwm_level` XOR invert (control bit 14). A change of the invert bit shows on the pin in the cycle after the write.
- R7: With sync disable (control bit 17) at 0 and run set, new divider, period and compare values take effect only when the counter wraps. The pulse in progress finishes with the old values.
- R8: With sync disable at 1, new divider, period and compare values take effect at the clock edge that accepts the write.
- R9: After reset, every control and timing field is zero, so `pwm_level`, `pwm_oe` and `pwm_pin` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word: divider fields and run, pin, invert, sync bits |
| duty_we | input | 1 | Write strobe for the timing word |
| duty_wdata | input | 32 | Timing word: start point, end point, period |
| pwm_level | output | 1 | Raw modulated level before inversion and pin gating |
| pwm_oe | output | 1 | Output-enable flag |
| pwm_pin | output | 1 | Final pin value |

## Verification
A prescaler that drifts, or a counter that wraps at the wrong value, changes the rising-to-rising distance of `pwm_level`. That distance is wrong in the very first full period measured. A staging register that copies at the wrong time shows as a pulse of the wrong length: the pulse in flight when the write lands, or the one straight after it. A bad run gate or pin gate shows within one cycle as a level that fails to drop, or as a pin that disagrees with the invert bit.

// File: rtl/pwm_dp_pkg.sv
package pwm_dp_pkg;
    localparam int DIVL_W = 8;
    localparam int DIVH_W = 4;
    localparam int CNT_W  = 8;
    localparam int WORD_W = 32;

    // control word bit positions
    localparam int CTL_DIVL_LSB = 0;
    localparam int CTL_DIVH_LSB = 8;
    localparam int CTL_PIN_BIT  = 12;
    localparam int CTL_INV_BIT  = 14;
    localparam int CTL_RUN_BIT  = 16;
    localparam int CTL_SYNC_BIT = 17;

    // timing word bit positions
    localparam int TIM_START_LSB = 0;
    localparam int TIM_END_LSB   = 8;
    localparam int TIM_PER_LSB   = 24;

    typedef struct packed {
        logic [DIVL_W-1:0] div_l;
        logic [DIVH_W-1:0] div_h;
        logic [CNT_W-1:0]  per;
        logic [CNT_W-1:0]  start;
        logic [CNT_W-1:0]  stop;
    } timing_t;

    typedef struct packed {
        timing_t stg;
        timing_t act;
        logic    pin_en;
        logic    inv;
        logic    run;
        logic    sync_dis;
    } chan_state_t;
endpackage

// File: rtl/pwm_dp_prescaler.sv
module pwm_dp_prescaler #(
    parameter int DIVL_W = 8,
    parameter int DIVH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIVL_W-1:0] div_l,
    input  logic [DIVH_W-1:0] div_h,
    output logic              tick
);
    localparam int QW = DIVL_W + (1 << DIVH_W);

    typedef struct packed {
        logic [QW-1:0] pcnt;
    } pre_state_t;

    pre_state_t    st_d, st_q;
    logic [QW-1:0] quant_len;
    logic [QW-1:0] quant_last;

    always_comb begin
        quant_len  = (QW'(div_l) + QW'(1)) << div_h;
        quant_last = quant_len - QW'(1);
        tick       = run && (st_q.pcnt >= quant_last);
        st_d       = st_q;
        if (!run || tick) begin
            st_d.pcnt = '0;
        end else begin
            st_d.pcnt = st_q.pcnt + QW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_dp_counter.sv
module pwm_dp_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        wrap = run && tick && (st_q.cnt >= period);
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/pwm_dp_compare.sv
module pwm_dp_compare #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] stop,
    input  logic             run,
    input  logic             pin_en,
    input  logic             inv,
    output logic             level,
    output logic             pin,
    output logic             oe
);
    logic in_window;

    always_comb begin
        if (start == stop) begin
            in_window = 1'b1;
        end else if (start < stop) begin
            in_window = (count >= start) && (count < stop);
        end else begin
            in_window = (count >= start) || (count < stop);
        end
        level = run && in_window;
        pin   = pin_en ? (level ^ inv) : inv;
        oe    = pin_en;
    end
endmodule

// File: rtl/pwm_dual_point_chan.sv
module pwm_dual_point_chan
    import pwm_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [WORD_W-1:0] ctrl_wdata,
    input  logic              duty_we,
    input  logic [WORD_W-1:0] duty_wdata,
    output logic              pwm_level,
    output logic              pwm_oe,
    output logic              pwm_pin
);
    chan_state_t      st_d, st_q;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic             run;
    logic             inv;
    logic             sync_dis;
    logic [CNT_W-1:0] act_start;
    logic [CNT_W-1:0] act_stop;
    logic [CNT_W-1:0] act_per;

    assign run       = st_q.run;
    assign inv       = st_q.inv;
    assign sync_dis  = st_q.sync_dis;
    assign act_start = st_q.act.start;
    assign act_stop  = st_q.act.stop;
    assign act_per   = st_q.act.per;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.stg.div_l = ctrl_wdata[CTL_DIVL_LSB +: DIVL_W];
            st_d.stg.div_h = ctrl_wdata[CTL_DIVH_LSB +: DIVH_W];
            st_d.pin_en    = ctrl_wdata[CTL_PIN_BIT];
            st_d.inv       = ctrl_wdata[CTL_INV_BIT];
            st_d.run       = ctrl_wdata[CTL_RUN_BIT];
            st_d.sync_dis  = ctrl_wdata[CTL_SYNC_BIT];
        end
        if (duty_we) begin
            st_d.stg.start = duty_wdata[TIM_START_LSB +: CNT_W];
            st_d.stg.stop  = duty_wdata[TIM_END_LSB +: CNT_W];
            st_d.stg.per   = duty_wdata[TIM_PER_LSB +: CNT_W];
        end
        // running copy follows staging at once when unsynchronised or idle,
        // otherwise only at the period boundary
        if (st_q.sync_dis || !st_q.run || wrap) begin
            st_d.act = st_d.stg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pwm_dp_prescaler #(
        .DIVL_W (DIVL_W),
        .DIVH_W (DIVH_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.run),
        .div_l (st_q.act.div_l),
        .div_h (st_q.act.div_h),
        .tick  (tick)
    );

    pwm_dp_counter #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.run),
        .tick   (tick),
        .period (st_q.act.per),
        .count  (count),
        .wrap   (wrap)
    );

    pwm_dp_compare #(
        .CNT_W (CNT_W)
    ) u_cmp (
        .count  (count),
        .start  (st_q.act.start),
        .stop   (st_q.act.stop),
        .run    (st_q.run),
        .pin_en (st_q.pin_en),
        .inv    (st_q.inv),
        .level  (pwm_level),
        .pin    (pwm_pin),
        .oe     (pwm_oe)
    );
endmodule

// File: rtl/pwm_dual_point_chan_sva.sv
module pwm_dual_point_chan_sva #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             inv,
    input logic             sync_dis,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] act_start,
    input logic [CNT_W-1:0] act_stop,
    input logic [CNT_W-1:0] act_per,
    input logic             level,
    input logic             pin,
    input logic             oe
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && count < act_per) |=> count == $past(count) + CNT_W'(1)); // R1
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == '0); // R1
    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_start == act_stop) |-> level); // R3
    AST_IDLE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == '0); // R4
    AST_PIN_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> pin == inv); // R5
    AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> pin == (level ^ inv)); // R6
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_dis && run && !wrap) |=> ($stable(act_start) && $stable(act_stop) && $stable(act_per))); // R7
endmodule

bind pwm_dual_point_chan pwm_dual_point_chan_sva #(.CNT_W(pwm_dp_pkg::CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .inv       (inv),
    .sync_dis  (sync_dis),
    .tick      (tick),
    .wrap      (wrap),
    .count     (count),
    .act_start (act_start),
    .act_stop  (act_stop),
    .act_per   (act_per),
    .level     (pwm_level),
    .pin       (pwm_pin),
    .oe        (pwm_oe)
);

// File: tb/pwm_dual_point_chan_bench.sv
module pwm_dual_point_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        duty_we = 1'b0;
    logic [31:0] duty_wdata = '0;
    logic        pwm_level;
    logic        pwm_oe;
    logic        pwm_pin;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pwm_dual_point_chan u_pwm_dual_point_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .duty_we    (duty_we),
        .duty_wdata (duty_wdata),
        .pwm_level  (pwm_level),
        .pwm_oe     (pwm_oe),
        .pwm_pin    (pwm_pin)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    function automatic logic [31:0] mk_ctrl(input int dl, input int dh, input bit pin,
                                            input bit iv, input bit rn, input bit sd);
        logic [31:0] w = '0;
        w[7:0]  = dl[7:0];
        w[11:8] = dh[3:0];
        w[12]   = pin;
        w[14]   = iv;
        w[16]   = rn;
        w[17]   = sd;
        return w;
    endfunction

    function automatic logic [31:0] mk_duty(input int a, input int b, input int p);
        logic [31:0] w = '0;
        w[7:0]   = a[7:0];
        w[15:8]  = b[7:0];
        w[31:24] = p[7:0];
        return w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at negedge, accepted at the following posedge
    task automatic wr_ctrl(input logic [31:0] w);
        ctrl_wdata = w;
        ctrl_we    = 1'b1;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic wr_duty(input logic [31:0] w);
        duty_wdata = w;
        duty_we    = 1'b1;
        @(negedge clk);
        duty_we    = 1'b0;
    endtask

    task automatic setup(input int dl, input int dh, input int a, input int b, input int p,
                         input bit pin, input bit iv, input bit sd);
        wr_ctrl(mk_ctrl(dl, dh, pin, iv, 1'b0, sd));
        wr_duty(mk_duty(a, b, p));
        wr_ctrl(mk_ctrl(dl, dh, pin, iv, 1'b1, sd));
    endtask

    task automatic wait_rise();
        logic prev = pwm_level;
        @(negedge clk);
        while (!(pwm_level && !prev)) begin
            prev = pwm_level;
            @(negedge clk);
        end
    endtask

    task automatic measure_period(output int n);
        wait_rise();
        n = 0;
        begin
            logic prev = pwm_level;
            do begin
                prev = pwm_level;
                @(negedge clk);
                n++;
            end while (!(pwm_level && !prev));
        end
    endtask

    task automatic count_high(input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pwm_level) n++;
        end
    endtask

    // counts high samples starting with the current one
    task automatic run_len(output int n);
        n = 0;
        while (pwm_level) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R9 level after reset", pwm_level, 0);
        check("R9 oe after reset", pwm_oe, 0);
        check("R9 pin after reset", pwm_pin, 0);
    endtask

    task automatic t_timing();
        int n;
        setup(1, 1, 2, 5, 9, 1'b1, 1'b0, 1'b0);
        measure_period(n);
        check("R1 period (1+1)<<1 x 10", n, 40);
        count_high(80, n);
        check("R1 high clocks in two periods", n, 24);
        setup(2, 0, 0, 1, 4, 1'b1, 1'b0, 1'b0);
        measure_period(n);
        check("R1 period 3 x 5", n, 15);
    endtask

    task automatic t_window();
        int n;
        setup(0, 0, 2, 5, 9, 1'b1, 1'b0, 1'b0);
        count_high(100, n);
        check("R2 start<end high count", n, 30);
        setup(0, 0, 7, 3, 9, 1'b1, 1'b0, 1'b0);
        count_high(100, n);
        check("R2 start>end wrapped high count", n, 60);
        setup(0, 0, 4, 4, 9, 1'b1, 1'b0, 1'b0);
        count_high(100, n);
        check("R3 equal points always high", n, 100);
    endtask

    task automatic t_run_gate();
        int n;
        setup(0, 0, 0, 5, 9, 1'b1, 1'b0, 1'b0);
        wait_rise();
        @(negedge clk);
        wr_ctrl(mk_ctrl(0, 0, 1'b1, 1'b0, 1'b0, 1'b0));
        check("R4 level drops at once when run cleared", pwm_level, 0);
        wr_duty(mk_duty(0, 3, 9));
        count_high(30, n);
        check("R4 level stays low while idle", n, 0);
        wr_ctrl(mk_ctrl(0, 0, 1'b1, 1'b0, 1'b1, 1'b0));
        run_len(n);
        check("R4 restart from zero with new end point", n, 3);
    endtask

    task automatic t_pin();
        int bad = 0;
        setup(0, 0, 2, 5, 9, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_pin !== 1'b0 || pwm_oe !== 1'b0) bad++;
        end
        check("R5 pin parked low, oe low", bad, 0);
        bad = 0;
        setup(0, 0, 2, 5, 9, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_pin !== 1'b1 || pwm_oe !== 1'b0) bad++;
        end
        check("R5 pin parked high when inverted", bad, 0);
    endtask

    task automatic t_invert();
        int bad = 0;
        int low = 0;
        setup(0, 0, 2, 5, 9, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_pin !== ~pwm_level) bad++;
            if (!pwm_pin) low++;
        end
        check("R6 inverted pin mismatches", bad, 0);
        check("R6 inverted pin low clocks", low, 30);
        wait_rise();
        wr_ctrl(mk_ctrl(0, 0, 1'b1, 1'b0, 1'b1, 1'b0));
        check("R6 pin follows invert change next cycle", pwm_pin, 1);
    endtask

    task automatic t_sync();
        int n;
        setup(0, 0, 0, 5, 9, 1'b1, 1'b0, 1'b0);
        wait_rise();
        duty_wdata = mk_duty(0, 8, 9);
        duty_we    = 1'b1;
        @(negedge clk);
        duty_we    = 1'b0;
        run_len(n);
        check("R7 pulse in flight keeps old end", n + 1, 5);
        wait_rise();
        run_len(n);
        check("R7 next pulse uses new end", n, 8);
        setup(0, 0, 0, 5, 9, 1'b1, 1'b0, 1'b1);
        wait_rise();
        duty_wdata = mk_duty(0, 8, 9);
        duty_we    = 1'b1;
        @(negedge clk);
        duty_we    = 1'b0;
        run_len(n);
        check("R8 unsynchronised write stretches current pulse", n + 1, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_window();
        t_run_gate();
        t_pin();
        t_invert();
        t_sync();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule